// File: doc/BRIEF.md
# Register Rename Stage

This block renames one instruction per clock. An instruction carries up to two source operands and an optional destination operand, each given as an architectural register index. Every index is first flattened: integer indices (below the floating-point boundary) are rotated by a context window offset modulo the integer register count, and all other indices are used as given. Each flattened source is looked up in a map table, which yields its physical register. A scoreboard supplies a ready bit for that register.

A destination takes the register at the head of a FIFO free list. The block reports the new register and the one the architectural index mapped to before, and from the next cycle the map points at the new register. The scoreboard bit of the new register is cleared. A history entry holding the sequence number, the flattened index, the new register and the previous register is pushed at the young end of a circular history buffer.

Commit retires history entries from the old end and frees each entry's previous register. Squash walks back from the young end, restores the map and frees each entry's new register. A writeback port sets scoreboard bits. Sequence numbers are compared as plain unsigned values and are assumed not to wrap inside the history window. Input indices are assumed to be below the architectural register count.

Top module: `rn_rename_top`

## Requirements
- R1: For an index below INT_REGS (8 by default) the flattened index is (index + win_ofs) mod INT_REGS. An index at or above INT_REGS is used unchanged.
- R2: src0_preg and src1_preg show, in the same cycle, the map entry of their flattened index. A map update made by a rename becomes visible from the next cycle.
- R3: srcN_rdy is the scoreboard bit of srcN_preg. A writeback of register p sets bit p, and the new value is visible from the next cycle.
- R4: dst_preg is the free-list head and dst_old_preg is the current map entry of the flattened destination. When a rename with a destination fires, that map entry becomes dst_preg. A source that names the same register in that instruction still reads the old mapping.
- R5: The scoreboard bit of dst_preg is cleared at the clock edge where the rename fires.
- R6: The free list is first-in first-out. After reset it hands out registers ARCH_REGS to PHYS_REGS-1 in ascending order. A register that is returned is handed out again only after every register queued ahead of it.
- R7: ren_ready is low while the free list is empty, while the history buffer holds HIST_DEPTH entries, or while a squash is being undone. A request made while ren_ready is low changes no map entry and consumes no free register.
- R8: A cmt_valid pulse records cmt_seq as the commit limit. While the oldest history entry has a sequence number at or below the limit, one entry is retired per cycle, and its previous register is appended to the free list.
- R9: A sq_valid pulse starts undo mode on the next edge, and ren_ready is low during undo mode. Each cycle, the youngest entry with a sequence number above sq_seq is popped. The pop restores its map entry to the previous register and appends its new register to the free list. The first cycle with nothing to pop returns the block to normal mode.
- R10: After reset, architectural register i maps to physical register i, every scoreboard bit is set, and ren_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_ofs | input | $clog2(INT_REGS) | Context window offset used for integer flattening |
| ren_valid | input | 1 | Rename request |
| ren_seq | input | SEQ_W | Sequence number of the instruction |
| src0_arch | input | $clog2(ARCH_REGS) | First source architectural index |
| src1_arch | input | $clog2(ARCH_REGS) | Second source architectural index |
| dst_valid | input | 1 | Instruction has a destination |
| dst_arch | input | $clog2(ARCH_REGS) | Destination architectural index |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| src0_preg | output | $clog2(PHYS_REGS) | Physical register of first source |
| src0_rdy | output | 1 | First source value is available |
| src1_preg | output | $clog2(PHYS_REGS) | Physical register of second source |
| src1_rdy | output | 1 | Second source value is available |
| dst_preg | output | $clog2(PHYS_REGS) | Newly allocated destination register |
| dst_old_preg | output | $clog2(PHYS_REGS) | Register the destination mapped to before |
| wb_valid | input | 1 | Writeback report |
| wb_preg | input | $clog2(PHYS_REGS) | Physical register that was written |
| cmt_valid | input | 1 | Commit limit update |
| cmt_seq | input | SEQ_W | Newest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Newest sequence number that survives the squash |

## Verification
The bench keeps INT_REGS=8, ARCH_REGS=12 and PHYS_REGS=20, so the free list holds eight registers, and it lowers HIST_DEPTH to 4. The free count always equals eight minus the history count, so at this setting the history-full stall is reached while four registers are still free. That lets the bench fill and drain the buffer twice and then see the committed previous registers handed out in FIFO order. The offsets 0, 2 and 7 cover flattening with and without wrap-around, and the twelve-entry map covers indices that pass through unchanged. With four history entries, a squash that pops two of three entries is easy to stage. The free-list-empty stall cannot be reached at this setting, because the history-full stall always comes first.

// File: rtl/rn_pkg.sv
// Shared constants and types for the rename stage.
// Assumes: nothing; holds default sizes and the mode encoding only.
package rn_pkg;
    localparam int RN_INT_REGS   = 8;
    localparam int RN_ARCH_REGS  = 12;
    localparam int RN_PHYS_REGS  = 20;
    localparam int RN_HIST_DEPTH = 8;
    localparam int RN_SEQ_W      = 8;

    typedef enum logic {
        RN_RUN  = 1'b0,
        RN_UNDO = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rn_flatten.sv
// Maps an architectural index to its flattened form.
// Integer indices (below INT_REGS) are rotated by the window offset modulo
// INT_REGS; all other indices pass through.
// Assumes: ofs < INT_REGS and INT_REGS <= 2**AW.
module rn_flatten #(
    parameter int INT_REGS = 8,
    parameter int AW       = 4,
    parameter int OW       = 3
) (
    input  logic [AW-1:0] arch_in,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] flat_out
);
    localparam int SW = AW + 1;

    logic [SW-1:0] sum;

    // Rotate integer indices inside the window; leave others alone.
    always_comb begin
        sum = SW'(arch_in) + SW'(ofs);
        if (sum >= SW'(INT_REGS)) sum = sum - SW'(INT_REGS);
        if (int'(arch_in) < INT_REGS) flat_out = sum[AW-1:0];
        else                          flat_out = arch_in;
    end
endmodule

// File: rtl/rn_free_list.sv
// FIFO of free physical registers.
// After reset it holds ARCH_REGS..PHYS_REGS-1 in ascending order.
// Assumes: at most one push and one pop per cycle; the caller never pops
// an empty list and never pushes a full one.
module rn_free_list #(
    parameter int PHYS_REGS = 20,
    parameter int ARCH_REGS = 12,
    parameter int PW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_preg,
    output logic [PW-1:0] head_preg,
    output logic          empty,
    output logic          full
);
    localparam int FREE_N = PHYS_REGS - ARCH_REGS;
    localparam int IW     = (FREE_N > 1) ? $clog2(FREE_N) : 1;
    localparam int CW     = $clog2(FREE_N + 1);

    logic [PW-1:0] slot_q [FREE_N];
    logic [IW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(FREE_N - 1)) ? '0 : p + 1'b1;
    endfunction

    // Hold the queue pointers, the count and the slot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FREE_N; i++) slot_q[i] <= PW'(ARCH_REGS + i);
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= CW'(FREE_N);
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_preg;
                wr_q         <= step(wr_q);
            end
            if (pop) rd_q <= step(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head_preg = slot_q[rd_q];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(FREE_N));

    // R7
    fl_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R6
    fl_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/rn_hist_buf.sv
// Circular rename history: pushes at the young end, retires from the
// old end on commit and pops from the young end on squash.
// Assumes: push and pop_young never in the same cycle; the caller never
// pushes when full and never pops when empty.
module rn_hist_buf #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [AW-1:0]    push_arch,
    input  logic [PW-1:0]    push_new,
    input  logic [PW-1:0]    push_prev,
    input  logic             pop_old,
    input  logic             pop_young,
    output logic [SEQ_W-1:0] old_seq,
    output logic [PW-1:0]    old_prev,
    output logic [SEQ_W-1:0] young_seq,
    output logic [AW-1:0]    young_arch,
    output logic [PW-1:0]    young_new,
    output logic [PW-1:0]    young_prev,
    output logic             empty,
    output logic             full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [AW-1:0]    arch_q [DEPTH];
    logic [PW-1:0]    new_q  [DEPTH];
    logic [PW-1:0]    prev_q [DEPTH];
    logic [IW-1:0]    head_q;
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    tail_idx, young_idx, head_nxt;

    // Work out the slot positions relative to the old end.
    always_comb begin
        tail_idx  = IW'((int'(head_q) + int'(cnt_q)) % DEPTH);
        young_idx = IW'((int'(head_q) + int'(cnt_q) + DEPTH - 1) % DEPTH);
        head_nxt  = IW'((int'(head_q) + 1) % DEPTH);
    end

    // Write new entries and move the old end and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                seq_q[tail_idx]  <= push_seq;
                arch_q[tail_idx] <= push_arch;
                new_q[tail_idx]  <= push_new;
                prev_q[tail_idx] <= push_prev;
            end
            if (pop_old) head_q <= head_nxt;
            cnt_q <= cnt_q + CW'(push) - CW'(pop_old) - CW'(pop_young);
        end
    end

    assign old_seq    = seq_q[head_q];
    assign old_prev   = prev_q[head_q];
    assign young_seq  = seq_q[young_idx];
    assign young_arch = arch_q[young_idx];
    assign young_new  = new_q[young_idx];
    assign young_prev = prev_q[young_idx];
    assign empty      = (cnt_q == '0);
    assign full       = (cnt_q == CW'(DEPTH));

    // R7
    hb_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9
    hb_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_young || pop_old) |-> !empty);
endmodule

// File: rtl/rn_rename_top.sv
// Single-wide rename stage: flattening, map lookup, scoreboard readiness,
// destination allocation, history push, commit retire and squash undo.
// Assumes: input indices < ARCH_REGS, win_ofs < INT_REGS, sequence numbers
// rise monotonically and do not wrap while they sit in the history.
module rn_rename_top #(
    parameter int INT_REGS   = rn_pkg::RN_INT_REGS,
    parameter int ARCH_REGS  = rn_pkg::RN_ARCH_REGS,
    parameter int PHYS_REGS  = rn_pkg::RN_PHYS_REGS,
    parameter int HIST_DEPTH = rn_pkg::RN_HIST_DEPTH,
    parameter int SEQ_W      = rn_pkg::RN_SEQ_W,
    parameter int AW         = $clog2(ARCH_REGS),
    parameter int PW         = $clog2(PHYS_REGS),
    parameter int OW         = $clog2(INT_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OW-1:0]    win_ofs,
    input  logic             ren_valid,
    input  logic [SEQ_W-1:0] ren_seq,
    input  logic [AW-1:0]    src0_arch,
    input  logic [AW-1:0]    src1_arch,
    input  logic             dst_valid,
    input  logic [AW-1:0]    dst_arch,
    output logic             ren_ready,
    output logic [PW-1:0]    src0_preg,
    output logic             src0_rdy,
    output logic [PW-1:0]    src1_preg,
    output logic             src1_rdy,
    output logic [PW-1:0]    dst_preg,
    output logic [PW-1:0]    dst_old_preg,
    input  logic             wb_valid,
    input  logic [PW-1:0]    wb_preg,
    input  logic             cmt_valid,
    input  logic [SEQ_W-1:0] cmt_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq
);
    import rn_pkg::*;

    localparam int N_OPS = 3;

    logic [PW-1:0]    map_q [ARCH_REGS];
    logic [PHYS_REGS-1:0] sb_q;
    rn_mode_e         mode_q;
    logic [SEQ_W-1:0] sq_lim_q;
    logic [SEQ_W-1:0] cmt_lim_q;
    logic             cmt_has_q;

    logic [AW-1:0]    raw_idx  [N_OPS];
    logic [AW-1:0]    flat_idx [N_OPS];

    logic             fl_empty, fl_full, fl_push;
    logic [PW-1:0]    fl_head, fl_push_preg;
    logic [SEQ_W-1:0] hb_o_seq, hb_y_seq;
    logic [AW-1:0]    hb_y_arch;
    logic [PW-1:0]    hb_o_prev, hb_y_new, hb_y_prev;
    logic             hb_empty, hb_full;
    logic             fire, alloc, retire, undo_pop;

    assign raw_idx[0] = src0_arch;
    assign raw_idx[1] = src1_arch;
    assign raw_idx[2] = dst_arch;

    // One flattener per operand slot.
    for (genvar g = 0; g < N_OPS; g++) begin : g_flat
        rn_flatten #(.INT_REGS(INT_REGS), .AW(AW), .OW(OW)) u_flat (
            .arch_in  (raw_idx[g]),
            .ofs      (win_ofs),
            .flat_out (flat_idx[g])
        );
    end

    // Decide what happens this cycle: rename, retire or undo.
    always_comb begin
        ren_ready = (mode_q == RN_RUN) && !fl_empty && !hb_full;
        fire      = ren_valid && ren_ready;
        alloc     = fire && dst_valid;
        retire    = (mode_q == RN_RUN) && cmt_has_q && !hb_empty &&
                    (hb_o_seq <= cmt_lim_q);
        undo_pop  = (mode_q == RN_UNDO) && !hb_empty && (hb_y_seq > sq_lim_q);
        fl_push      = retire || undo_pop;
        fl_push_preg = retire ? hb_o_prev : hb_y_new;
    end

    // Read the map and scoreboard for the operands.
    always_comb begin
        src0_preg    = map_q[flat_idx[0]];
        src1_preg    = map_q[flat_idx[1]];
        src0_rdy     = sb_q[src0_preg];
        src1_rdy     = sb_q[src1_preg];
        dst_preg     = fl_head;
        dst_old_preg = map_q[flat_idx[2]];
    end

    // Update the map on allocation or restore it on undo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
        end else if (alloc) begin
            map_q[flat_idx[2]] <= fl_head;
        end else if (undo_pop) begin
            map_q[hb_y_arch] <= hb_y_prev;
        end
    end

    // Set ready bits on writeback; clear the bit of a new allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q <= '1;
        end else begin
            if (wb_valid) sb_q[wb_preg] <= 1'b1;
            if (alloc)    sb_q[fl_head] <= 1'b0;
        end
    end

    // Track undo mode and its limit, and the commit limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= RN_RUN;
            sq_lim_q  <= '0;
            cmt_lim_q <= '0;
            cmt_has_q <= 1'b0;
        end else begin
            if (sq_valid) begin
                mode_q   <= RN_UNDO;
                sq_lim_q <= sq_seq;
            end else if (mode_q == RN_UNDO && !undo_pop) begin
                mode_q <= RN_RUN;
            end
            if (cmt_valid) begin
                cmt_lim_q <= cmt_seq;
                cmt_has_q <= 1'b1;
            end
        end
    end

    rn_free_list #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS), .PW(PW)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc),
        .push      (fl_push),
        .push_preg (fl_push_preg),
        .head_preg (fl_head),
        .empty     (fl_empty),
        .full      (fl_full)
    );

    rn_hist_buf #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (alloc),
        .push_seq   (ren_seq),
        .push_arch  (flat_idx[2]),
        .push_new   (fl_head),
        .push_prev  (dst_old_preg),
        .pop_old    (retire),
        .pop_young  (undo_pop),
        .old_seq    (hb_o_seq),
        .old_prev   (hb_o_prev),
        .young_seq  (hb_y_seq),
        .young_arch (hb_y_arch),
        .young_new  (hb_y_new),
        .young_prev (hb_y_prev),
        .empty      (hb_empty),
        .full       (hb_full)
    );

    // R5
    alloc_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> !sb_q[$past(fl_head)]);
    // R3
    wb_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(alloc && fl_head == wb_preg)) |=> sb_q[$past(wb_preg)]);
    // R4
    fresh_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (dst_preg != dst_old_preg));
    // R9
    undo_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undo_pop |=> (map_q[$past(hb_y_arch)] == $past(hb_y_prev)));
    // R8
    retire_no_undo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> !undo_pop);
endmodule

// File: tb/tb_rn_rename_top.sv
`timescale 1ns/1ps
module tb_rn_rename_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] win_ofs = '0;
    logic       ren_valid = 1'b0;
    logic [7:0] ren_seq = '0;
    logic [3:0] src0_arch = '0, src1_arch = '0, dst_arch = '0;
    logic       dst_valid = 1'b0;
    logic       ren_ready, src0_rdy, src1_rdy;
    logic [4:0] src0_preg, src1_preg, dst_preg, dst_old_preg;
    logic       wb_valid = 1'b0;
    logic [4:0] wb_preg = '0;
    logic       cmt_valid = 1'b0;
    logic [7:0] cmt_seq = '0;
    logic       sq_valid = 1'b0;
    logic [7:0] sq_seq = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rn_rename_top #(.HIST_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .win_ofs(win_ofs),
        .ren_valid(ren_valid), .ren_seq(ren_seq),
        .src0_arch(src0_arch), .src1_arch(src1_arch),
        .dst_valid(dst_valid), .dst_arch(dst_arch),
        .ren_ready(ren_ready),
        .src0_preg(src0_preg), .src0_rdy(src0_rdy),
        .src1_preg(src1_preg), .src1_rdy(src1_rdy),
        .dst_preg(dst_preg), .dst_old_preg(dst_old_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq)
    );

    typedef struct packed {
        logic [3:0] s0, s1, d;
        logic [2:0] ofs;
        logic [7:0] seq;
        logic [4:0] e0, e1;
        logic       r0, r1;
        logic [4:0] ed, eo;
    } vec_t;

    // Four renames from reset: offsets 0, 2, 0, 7; fills the 4-deep history.
    localparam vec_t VEC [4] = '{
        '{4'd1,  4'd9,  4'd3,  3'd0, 8'd1, 5'd1,  5'd9,  1'b1, 1'b1, 5'd12, 5'd3},
        '{4'd1,  4'd7,  4'd10, 3'd2, 8'd2, 5'd12, 5'd1,  1'b0, 1'b1, 5'd13, 5'd10},
        '{4'd10, 4'd3,  4'd3,  3'd0, 8'd3, 5'd13, 5'd12, 1'b0, 1'b0, 5'd14, 5'd12},
        '{4'd4,  4'd11, 4'd4,  3'd7, 8'd4, 5'd14, 5'd11, 1'b0, 1'b1, 5'd15, 5'd14}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_ren(input logic v, input int s0, input int s1,
                           input logic dv, input int d, input int ofs, input int seq);
        ren_valid = v;
        src0_arch = 4'(s0);
        src1_arch = 4'(s1);
        dst_valid = dv;
        dst_arch  = 4'(d);
        win_ofs   = 3'(ofs);
        ren_seq   = 8'(seq);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        set_ren(0, 11, 0, 0, 0, 0, 0);
        #1;
        chk("R10 ready", int'(ren_ready), 1);
        chk("R10 first free", int'(dst_preg), 12);
        chk("R10 map 11", int'(src0_preg), 11);
        chk("R10 rdy", int'(src0_rdy), 1);
        chk("R10 map 0", int'(src1_preg), 0);

        // Table walk: R1 flattening, R2 lookup, R4 allocation, R5 ready clear
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            set_ren(1, int'(VEC[i].s0), int'(VEC[i].s1), 1, int'(VEC[i].d),
                    int'(VEC[i].ofs), int'(VEC[i].seq));
            #1;
            chk("R7 ready in table", int'(ren_ready), 1);
            chk("R1/R2 src0", int'(src0_preg), int'(VEC[i].e0));
            chk("R1/R2 src1", int'(src1_preg), int'(VEC[i].e1));
            chk("R5 src0 rdy", int'(src0_rdy), int'(VEC[i].r0));
            chk("R5 src1 rdy", int'(src1_rdy), int'(VEC[i].r1));
            chk("R4 new", int'(dst_preg), int'(VEC[i].ed));
            chk("R4 old", int'(dst_old_preg), int'(VEC[i].eo));
        end

        // R7 history full: request is ignored
        @(negedge clk);
        set_ren(1, 5, 5, 1, 5, 0, 99);
        #1;
        chk("R7 stall on full history", int'(ren_ready), 0);
        @(negedge clk);
        set_ren(0, 5, 0, 0, 0, 0, 0);
        wb_valid = 1'b1;
        wb_preg  = 5'd13;
        #1;
        chk("R7 map untouched", int'(src0_preg), 5);
        chk("R7 free list untouched", int'(dst_preg), 16);

        // R3 writeback sets readiness from the next cycle
        @(negedge clk);
        wb_valid = 1'b0;
        set_ren(0, 10, 0, 0, 0, 0, 0);
        #1;
        chk("R3 preg", int'(src0_preg), 13);
        chk("R3 rdy after wb", int'(src0_rdy), 1);

        // R8 commit up to seq 4 drains history
        @(negedge clk);
        cmt_valid = 1'b1;
        cmt_seq   = 8'd4;
        @(negedge clk);
        cmt_valid = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R8 ready after retire", int'(ren_ready), 1);

        // R6 remaining reset-time registers come out in order
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            set_ren(1, 0, 0, 1, (j == 3) ? 5 : j, 0, 5 + j);
            #1;
            chk("R6 ascending alloc", int'(dst_preg), 16 + j);
            chk("R4 old in phase two", int'(dst_old_preg), (j == 3) ? 5 : j);
        end
        @(negedge clk);
        set_ren(0, 0, 0, 0, 0, 0, 0);
        cmt_valid = 1'b1;
        cmt_seq   = 8'd8;
        @(negedge clk);
        cmt_valid = 1'b0;
        repeat (5) @(negedge clk);

        // R6 and R8: first register freed by commit is reused next
        @(negedge clk);
        set_ren(1, 0, 0, 1, 6, 0, 9);
        #1;
        chk("R8 freed prev reused", int'(dst_preg), 3);
        chk("R4 old seq9", int'(dst_old_preg), 6);
        @(negedge clk);
        set_ren(1, 6, 0, 1, 7, 0, 10);
        #1;
        chk("R2 updated map", int'(src0_preg), 3);
        chk("R5 cleared on alloc", int'(src0_rdy), 0);
        chk("R6 fifo second", int'(dst_preg), 10);
        chk("R4 old seq10", int'(dst_old_preg), 7);
        @(negedge clk);
        set_ren(1, 7, 7, 1, 7, 0, 11);
        #1;
        chk("R4 src sees old map", int'(src0_preg), 10);
        chk("R6 fifo third", int'(dst_preg), 12);
        chk("R4 old seq11", int'(dst_old_preg), 10);

        // R9 squash back to seq 9
        @(negedge clk);
        set_ren(0, 0, 0, 0, 0, 0, 0);
        sq_valid = 1'b1;
        sq_seq   = 8'd9;
        @(negedge clk);
        sq_valid = 1'b0;
        #1;
        chk("R9 ready low in undo", int'(ren_ready), 0);
        repeat (4) @(negedge clk);
        set_ren(0, 7, 6, 1, 7, 0, 0);
        #1;
        chk("R9 ready back", int'(ren_ready), 1);
        chk("R9 map restored", int'(src0_preg), 7);
        chk("R9 survivor kept", int'(src1_preg), 3);
        chk("R9 old after restore", int'(dst_old_preg), 7);
        chk("R9 free head", int'(dst_preg), 14);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule